// File: doc/BRIEF.md
# Valid/Ready Hold Checker

This block is a synthesizable protocol checker for a single valid/ready channel of a memory-mapped bus. It taps a channel without driving it. The inputs are the valid and ready wires and one packed vector. That vector concatenates every field the sender owns on the channel: address or data, control, identifier and user sideband. The block registers the previous cycle's handshake state and payload. It then reports three kinds of sender misbehaviour on sticky flags: payload motion during a stall, valid withdrawn before acceptance, and valid raised too early around reset release.

One instance is placed per channel. The payload width is a parameter, so the same block covers the write-address, write-data, write-response, read-address and read-data channels of one port. The payload comparison is split into lanes of a parameterised width, and the per-lane results are OR-reduced. A sender with a wide data bus therefore gets a balanced compare tree instead of one long XOR chain. All state uses a synchronous active-low reset. The flags can be cleared only by reset.

Top module: `hs_hold_monitor`

## Requirements
- R1: When the previous sampled edge had valid high and ready low, a difference in any payload bit at the current edge sets `flag_payload_chg`. The flag is visible right after the current edge. Every bit counts, from bit 0 up to bit PAYLOAD_W-1.
- R2: When the previous sampled edge had valid high and ready low, valid low at the current edge sets `flag_valid_drop` right after the current edge.
- R3: `flag_early_valid` is set in either of two cases, each taken at the first edge with reset high: valid was high at the last edge with reset low, or valid is high at that first edge.
- R4: When the previous sampled edge had valid and ready both high, or had valid low, neither a payload change nor valid low at the current edge sets any flag.
- R5: Each flag stays set until an edge that samples reset low. Every edge that samples reset low clears all three flags.
- R6: `any_error` is high exactly when at least one of the three flags is high, with no added cycle of delay.
- R7: Payload changes while valid is low never set a flag, whatever ready does.
- R8: Valid first raised at the second edge after release, or later, does not set `flag_early_valid`.
- R9: A payload change and a valid drop detected at the same edge set both `flag_payload_chg` and `flag_valid_drop` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset, same net as the channel's |
| valid | input | 1 | Sender's valid of the watched channel |
| ready | input | 1 | Receiver's ready of the watched channel |
| payload | input | PAYLOAD_W | Concatenation of every sender-driven field of the channel |
| flag_payload_chg | output | 1 | Sticky: payload moved during a stall |
| flag_valid_drop | output | 1 | Sticky: valid fell before acceptance |
| flag_early_valid | output | 1 | Sticky: valid high too soon around reset release |
| any_error | output | 1 | OR of the three sticky flags |

## Verification
Two functions can fall in the same cycle. The first is the payload comparison against the registered copy. The second is the valid-drop test, which both depend on one stall bit. The bench provokes this by stalling a transfer and then, on the next edge, lowering valid and flipping a payload bit together. Both flags must be set after that single edge, and no extra cycle of delay is allowed on either. A per-cycle behavioural model, fed by a long random stream with forced stalls and repeated resets, judges every edge. It also covers the overlap of reset release with a hold check, where the stall state must not carry across reset.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;

   // Encoded violation kinds, also the bit order of the sticky vector.
   localparam int unsigned VIOL_CHG   = 0;
   localparam int unsigned VIOL_DROP  = 1;
   localparam int unsigned VIOL_EARLY = 2;
   localparam int unsigned VIOL_KINDS = 3;

   typedef logic [VIOL_KINDS-1:0] viol_vec_t;

   // Number of compare lanes needed to cover a payload.
   function automatic int unsigned lane_count(int unsigned width, int unsigned lane_w);
      return (width + lane_w - 1) / lane_w;
   endfunction

endpackage

// File: rtl/hs_hold_pipe.sv
module hs_hold_pipe #(
   parameter int unsigned PAYLOAD_W = 64,
   parameter int unsigned LANE_W    = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid,
   input  logic                 ready,
   input  logic [PAYLOAD_W-1:0] payload,
   output logic                 viol_chg,
   output logic                 viol_drop
);
   import hs_mon_pkg::*;

   localparam int unsigned N_LANES = lane_count(PAYLOAD_W, LANE_W);
   localparam int unsigned PAD_W   = N_LANES * LANE_W;

   if (PAYLOAD_W < 1) begin : g_bad_width
      $error("hs_hold_pipe: PAYLOAD_W must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("hs_hold_pipe: LANE_W must be at least 1");
   end

   logic                 stall_q;
   logic [PAYLOAD_W-1:0] prev_q;
   logic [PAD_W-1:0]     cur_pad;
   logic [PAD_W-1:0]     prev_pad;
   logic [N_LANES-1:0]   lane_diff;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stall_q <= 1'b0;
         prev_q  <= '0;
      end else begin
         stall_q <= valid & ~ready;
         prev_q  <= payload;
      end
   end

   assign cur_pad  = PAD_W'(payload);
   assign prev_pad = PAD_W'(prev_q);

   for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      assign lane_diff[l] = |(cur_pad[l*LANE_W +: LANE_W] ^ prev_pad[l*LANE_W +: LANE_W]);
   end

   assign viol_chg  = stall_q & (|lane_diff);
   assign viol_drop = stall_q & ~valid;

   // R7: with valid low on the previous edge no hold violation may be raised.
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(valid)) |-> (!viol_chg && !viol_drop));

endmodule

// File: rtl/hs_rst_guard.sv
module hs_rst_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   output logic viol_early
);
   logic first_q;   // next non-reset edge is the first after release
   logic rst_vld_q; // valid as sampled at the last reset edge

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q   <= 1'b1;
         rst_vld_q <= valid;
      end else begin
         first_q   <= 1'b0;
         rst_vld_q <= 1'b0;
      end
   end

   assign viol_early = rst_n & first_q & (valid | rst_vld_q);

   // R8: from the second edge after release on, valid is never early.
   a_r8_late_ok: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> !viol_early);

endmodule

// File: rtl/hs_sticky.sv
module hs_sticky #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   output logic [N-1:0] flags
);
   if (N < 1) begin : g_bad_n
      $error("hs_sticky: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) flags[i] <= 1'b0;
         else        flags[i] <= flags[i] | set[i];
      end
   end

   // R5: a set flag never clears while reset stays high.
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && rst_n) |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/hs_hold_monitor.sv
module hs_hold_monitor #(
   parameter int unsigned PAYLOAD_W = 64,
   parameter int unsigned LANE_W    = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid,
   input  logic                 ready,
   input  logic [PAYLOAD_W-1:0] payload,
   output logic                 flag_payload_chg,
   output logic                 flag_valid_drop,
   output logic                 flag_early_valid,
   output logic                 any_error
);
   import hs_mon_pkg::*;

   viol_vec_t viol_now;
   viol_vec_t sticky;

   hs_hold_pipe #(
      .PAYLOAD_W (PAYLOAD_W),
      .LANE_W    (LANE_W)
   ) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (valid),
      .ready     (ready),
      .payload   (payload),
      .viol_chg  (viol_now[VIOL_CHG]),
      .viol_drop (viol_now[VIOL_DROP])
   );

   hs_rst_guard u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (valid),
      .viol_early (viol_now[VIOL_EARLY])
   );

   hs_sticky #(.N(VIOL_KINDS)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (viol_now),
      .flags (sticky)
   );

   assign flag_payload_chg = sticky[VIOL_CHG];
   assign flag_valid_drop  = sticky[VIOL_DROP];
   assign flag_early_valid = sticky[VIOL_EARLY];
   assign any_error        = |sticky;

   // R1: payload moved after a stalled edge.
   a_r1_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(valid) && !$past(ready) && (payload != $past(payload)))
      |=> flag_payload_chg);

   // R2: valid withdrawn after a stalled edge.
   a_r2_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(valid) && !$past(ready) && !valid) |=> flag_valid_drop);

   // R3: valid high at the first edge after release.
   a_r3_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rst_n) && valid) |=> flag_early_valid);

   // R4: an accepted transfer frees both payload and valid.
   a_r4_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(valid) && $past(ready) && !flag_payload_chg && !flag_valid_drop)
      |=> (!flag_payload_chg && !flag_valid_drop));

endmodule

// File: tb/test_hs_hold_monitor.sv
`timescale 1ns/1ps
module test_hs_hold_monitor;
   localparam int W = 36;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         valid = 1'b0;
   logic         ready = 1'b0;
   logic [W-1:0] payload = '0;
   logic         f_chg, f_drop, f_early, f_any;

   hs_hold_monitor #(.PAYLOAD_W(W), .LANE_W(8)) i_hs_hold_monitor (
      .clk (clk), .rst_n (rst_n), .valid (valid), .ready (ready), .payload (payload),
      .flag_payload_chg (f_chg), .flag_valid_drop (f_drop),
      .flag_early_valid (f_early), .any_error (f_any)
   );

   always #4 clk = ~clk; // 125 MHz

   int    n_chk = 0;
   int    n_err = 0;
   bit    running = 0;
   bit    done = 0;
   string phase = "R5";

   // Behavioural reference: remembers what the previous edge saw.
   bit           m_in_reset = 1;
   bit           m_just_released = 0;
   bit           m_valid_at_reset = 0;
   bit           m_pending = 0;
   logic [W-1:0] m_last;
   bit           e_chg = 0, e_drop = 0, e_early = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_in_reset = 1;
         m_valid_at_reset = valid;
         m_pending = 0;
         e_chg = 0; e_drop = 0; e_early = 0;
      end else begin
         m_just_released = m_in_reset;
         m_in_reset = 0;
         if (m_just_released && (valid || m_valid_at_reset)) e_early = 1;
         if (m_pending && payload !== m_last) e_chg = 1;
         if (m_pending && !valid) e_drop = 1;
         m_pending = valid && !ready;
         m_last = payload;
      end
   end

   task automatic check(string tag, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (running) begin
         check(phase, "flag_payload_chg", f_chg, e_chg);
         check(phase, "flag_valid_drop", f_drop, e_drop);
         check(phase, "flag_early_valid", f_early, e_early);
         check("R6", "any_error", f_any, e_chg | e_drop | e_early);
      end
   end

   task automatic drive(logic v, logic r, logic [W-1:0] p);
      @(negedge clk);
      valid = v; ready = r; payload = p;
   endtask

   task automatic do_reset(logic v_in_reset, logic v_at_release);
      @(negedge clk);
      rst_n = 1'b0; valid = v_in_reset; ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; valid = v_at_release;
   endtask

   initial begin
      logic [W-1:0] a;
      repeat (3) @(negedge clk);
      running = 1;
      do_reset(0, 0);
      check("R5", "reset clears chg", f_chg, 1'b0);
      check("R5", "reset clears any", f_any, 1'b0);

      phase = "R4";
      drive(0, 0, 36'h0);
      drive(1, 1, 36'h1234);
      drive(1, 1, 36'h5678);
      drive(1, 0, 36'h9abc);
      drive(1, 1, 36'h9abc);
      drive(0, 0, 36'hfff00);
      drive(0, 0, 36'hfff00);
      check("R4", "no chg after accept", f_chg, 1'b0);
      check("R4", "no drop after accept", f_drop, 1'b0);
      check("R8", "valid at second edge not early", f_early, 1'b0);

      phase = "R7";
      for (int i = 0; i < 8; i++) drive(0, i[0], {4'(i), 32'($urandom)});
      drive(0, 0, 36'h0);
      check("R7", "idle changes ignored", f_any, 1'b0);

      phase = "R1";
      a = 36'h3_0F0F_1234;
      drive(1, 0, a);
      drive(1, 0, a);
      drive(1, 0, a ^ (36'(1) << 35));
      drive(1, 1, a ^ (36'(1) << 35));
      drive(0, 0, 36'h0);
      check("R1", "top bit change flagged", f_chg, 1'b1);
      check("R1", "no drop", f_drop, 1'b0);
      check("R6", "any_error follows", f_any, 1'b1);

      phase = "R5";
      repeat (4) drive(0, 0, 36'h0);
      check("R5", "chg sticky", f_chg, 1'b1);
      do_reset(0, 0);
      check("R5", "reset clears sticky", f_chg, 1'b0);

      phase = "R2";
      drive(0, 0, 36'h0);
      drive(1, 0, 36'h55);
      drive(0, 0, 36'h55);
      drive(0, 0, 36'h55);
      check("R2", "valid drop flagged", f_drop, 1'b1);
      check("R2", "payload held", f_chg, 1'b0);

      do_reset(0, 0);
      phase = "R9";
      drive(0, 0, 36'h0);
      drive(1, 0, 36'hA0);
      drive(0, 0, 36'hA1);
      drive(0, 0, 36'h0);
      check("R9", "both: chg", f_chg, 1'b1);
      check("R9", "both: drop", f_drop, 1'b1);

      phase = "R3";
      do_reset(1, 0);
      drive(0, 0, 36'h0);
      check("R3", "valid at last reset edge", f_early, 1'b1);
      do_reset(0, 1);
      drive(0, 0, 36'h0);
      check("R3", "valid at first edge", f_early, 1'b1);
      check("R2", "no hold check across reset", f_drop, 1'b0);

      phase = "R8";
      do_reset(0, 0);
      drive(1, 0, 36'h77);
      drive(1, 1, 36'h77);
      drive(0, 0, 36'h0);
      check("R8", "second edge valid legal", f_early, 1'b0);

      phase = "R1";
      for (int i = 0; i < 3000; i++) begin
         if (i % 500 == 499) do_reset($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
         else begin
            logic v, r;
            logic [W-1:0] p;
            v = ($urandom_range(0, 3) != 0) || (valid && !ready && $urandom_range(0, 15) != 0);
            r = $urandom_range(0, 2) == 0;
            p = (valid && !ready && $urandom_range(0, 15) != 0) ? payload
                                                                : {4'($urandom), 32'($urandom)};
            drive(v, r, p);
         end
      end
      drive(0, 0, 36'h0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired phase=%s actual=hung expected=done", phase);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule